// File: doc/BRIEF.md
# Startup Bus Role Selector for a Two-Wire Bus

This block connects a device core to an open-drain two-wire bus (clock and data lines, 7-bit addressing, standard mode). Right after reset it acts briefly as a bus master and tests whether a non-volatile memory sits at a fixed bus address. It writes a test byte to one memory location, points back at that location, and reads it again. The outcome sets the device's bus role until the next reset.

If every byte of the test is acknowledged and the read-back byte equals the test byte, the block keeps the master role. Otherwise it takes the slave role. As a slave it watches the bus for a START, compares the first received byte with its own 7-bit address, acknowledges a match, and reports the transfer direction. The own address is a fixed default of 0x42 unless a configuration input supplies another one. That choice is captured once, when the test finishes.

All pins are plain level or strobe signals. The block has no streaming data interface, so no back-pressure applies. The line outputs are pull-down enables: a 1 pulls the wire low, and a 0 releases it to the pull-up.

Top module: `bus_role_picker`

## Requirements
- R1: While reset is held, both pull outputs are 0 (lines released) and `role_master`, `probe_done`, `addr_hit` are 0.
- R2: The probe puts these bytes on the wire in this order: START, 0xA0, location, test byte, STOP, START, 0xA0, location, repeated START, 0xA1, then one byte read with a NACK, then STOP. That is six written bytes, three START conditions and two STOPs. The location defaults to 0x00 and the test byte to 0xA5, and both are parameters. 0xA0/0xA1 are the fixed memory address 0x50 shifted left, with R/W in bit 0.
- R3: The probe clock uses a quarter period Q = ceil(CLK_HZ / (4*SCL_HZ)) system cycles. It stays high for 2Q and low for 2Q, so its rise-to-rise period is never below CLK_HZ/SCL_HZ cycles.
- R4: `probe_done` is a one-cycle strobe that occurs exactly once per reset. When it is high, both lines are released.
- R5: `role_master` is 1 only if all written probe bytes were acknowledged (SDA low on the ninth clock) and the read byte equals the test byte. It changes only together with `probe_done` and is then held until reset.
- R6: A NACK on any probe byte ends the probe at once with a STOP, and slave role is selected. If the memory address itself is not acknowledged, the wire carries only 0xA0 plus one START and one STOP.
- R7: If all bytes are acknowledged but the read-back byte differs from the test byte, slave role is selected.
- R8: At `probe_done` the own address is latched: `cfg_addr` if `cfg_addr_en` is 1, else 0x42. Later changes to `cfg_addr` or `cfg_addr_en` have no effect.
- R9: In slave role, after a START whose first byte carries the own address in bits 7:1, the block pulls SDA low through the ninth clock. After that clock's falling edge it raises `addr_hit` and sets `addr_rd` to bit 0 of the byte (1 = read), and holds both until a STOP. For the default address, 0x84 gives `addr_rd`=0 and 0x85 gives `addr_rd`=1.
- R10: In slave role, a first byte with a different address gets no ACK and leaves `addr_hit` at 0.
- R11: In master role the block never acknowledges or reports any address, and after `probe_done` it never pulls SCL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset; starts the probe when released |
| cfg_addr_en | input | 1 | 1 selects `cfg_addr` as own address at probe end |
| cfg_addr | input | 7 | Configured own 7-bit slave address |
| scl_i | input | 1 | Sensed clock line level |
| sda_i | input | 1 | Sensed data line level |
| scl_pull | output | 1 | 1 pulls the clock line low |
| sda_pull | output | 1 | 1 pulls the data line low |
| role_master | output | 1 | Selected role: 1 master, 0 slave |
| probe_done | output | 1 | One-cycle strobe when the role is settled |
| addr_hit | output | 1 | Own address matched; held until STOP |
| addr_rd | output | 1 | Direction bit of the matched address byte |

## Verification
The properties assume that no other node drives SCL while the probe runs. They also assume that every external partner holds each SCL and SDA level for several system cycles, longer than the two-flop synchronizer delay, and changes SDA only while SCL is low except to form START and STOP. The bench's memory model reacts only to the probe's own clock edges. Its bus-master stimulus starts only after `probe_done`, with half periods of 20 system cycles, and configuration changes are made only well before or well after the probe ends.

// File: rtl/bus_role_pkg.sv
package bus_role_pkg;

  // One bus action per probe step
  typedef enum logic [1:0] {OP_START, OP_WR, OP_RD, OP_STOP} op_e;

  localparam logic [3:0] LAST_STEP    = 4'd11;
  localparam logic [6:0] FACTORY_ADDR = 7'h42;

  // Probe program: write test byte, point back, repeated start, read
  function automatic op_e step_op(input logic [3:0] s);
    case (s)
      4'd0, 4'd5, 4'd8: step_op = OP_START;
      4'd4, 4'd11:      step_op = OP_STOP;
      4'd10:            step_op = OP_RD;
      default:          step_op = OP_WR;
    endcase
  endfunction

endpackage

// File: rtl/line_sync.sv
module line_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  // Idle bus level is high, so both stages reset to 1
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '1;
      q    <= '1;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/probe_master.sv
module probe_master
  import bus_role_pkg::*;
#(
  parameter int         CLK_HZ    = 125_000_000,
  parameter int         SCL_HZ    = 100_000,
  parameter logic [6:0] MEM_ADDR  = 7'h50,
  parameter logic [7:0] MEM_LOC   = 8'h00,
  parameter logic [7:0] TEST_BYTE = 8'hA5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_pull,
  output logic sda_pull,
  output logic done_pulse,
  output logic pass
);
  localparam int QTR_RAW = (CLK_HZ + 4 * SCL_HZ - 1) / (4 * SCL_HZ);
  localparam int QTR     = (QTR_RAW < 3) ? 3 : QTR_RAW;
  localparam int QW      = $clog2(QTR);

  logic [QW-1:0] qcnt;
  logic          running;
  logic [3:0]    step;
  logic [1:0]    phase;
  logic [3:0]    bitn;
  logic [7:0]    shreg;
  logic          nack;
  logic [7:0]    wbyte;
  op_e           op;

  wire tick = (qcnt == QW'(QTR - 1));

  // Quarter-period divider
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       qcnt <= '0;
    else if (running) qcnt <= tick ? '0 : qcnt + 1'b1;
  end

  assign op = step_op(step);

  always_comb begin
    case (step)
      4'd1, 4'd6: wbyte = {MEM_ADDR, 1'b0};
      4'd2, 4'd7: wbyte = MEM_LOC;
      4'd3:       wbyte = TEST_BYTE;
      4'd9:       wbyte = {MEM_ADDR, 1'b1};
      default:    wbyte = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running    <= 1'b1;
      step       <= '0;
      phase      <= '0;
      bitn       <= '0;
      scl_pull   <= 1'b0;
      sda_pull   <= 1'b0;
      shreg      <= '0;
      nack       <= 1'b0;
      done_pulse <= 1'b0;
      pass       <= 1'b0;
    end else begin
      done_pulse <= 1'b0;
      if (running && tick) begin
        phase <= phase + 2'd1;
        case (op)
          OP_START: begin
            case (phase)
              2'd0: sda_pull <= 1'b0;
              2'd1: scl_pull <= 1'b0;
              2'd2: sda_pull <= 1'b1;
              default: begin
                scl_pull <= 1'b1;
                step     <= step + 4'd1;
              end
            endcase
          end
          OP_STOP: begin
            case (phase)
              2'd0: begin
                scl_pull <= 1'b1;
                sda_pull <= 1'b1;
              end
              2'd1: scl_pull <= 1'b0;
              2'd2: sda_pull <= 1'b0;
              default: begin
                if (step == LAST_STEP) begin
                  running    <= 1'b0;
                  done_pulse <= 1'b1;
                  pass       <= !nack && (shreg == TEST_BYTE);
                end else begin
                  step <= step + 4'd1;
                end
              end
            endcase
          end
          default: begin
            case (phase)
              2'd0: begin
                scl_pull <= 1'b1;
                sda_pull <= (op == OP_WR && bitn < 4'd8) ? ~wbyte[3'd7 - bitn[2:0]] : 1'b0;
              end
              2'd1: scl_pull <= 1'b0;
              2'd2: begin
                if (bitn < 4'd8) begin
                  if (op == OP_RD) shreg <= {shreg[6:0], sda_s};
                end else if (op == OP_WR && sda_s) begin
                  nack <= 1'b1;
                end
              end
              default: begin
                scl_pull <= 1'b1;
                if (bitn == 4'd8) begin
                  bitn <= '0;
                  step <= nack ? LAST_STEP : step + 4'd1;
                end else begin
                  bitn <= bitn + 4'd1;
                end
              end
            endcase
          end
        endcase
      end
    end
  end

  // Clock line level is only driven, never read back (no stretching)
  logic unused_scl;
  assign unused_scl = scl_s;
endmodule

// File: rtl/addr_matcher.sv
module addr_matcher (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [6:0] my_addr,
  input  logic       scl_s,
  input  logic       sda_s,
  output logic       sda_pull,
  output logic       hit,
  output logic       rd
);
  typedef enum logic [2:0] {M_IDLE, M_ADDR, M_ACK, M_HELD, M_SKIP} mstate_e;

  mstate_e    st;
  logic       scl_q, sda_q;
  logic [7:0] sh;
  logic [3:0] cnt;

  wire scl_rise = scl_s && !scl_q;
  wire scl_fall = !scl_s && scl_q;
  wire bus_start = scl_s && scl_q && sda_q && !sda_s;
  wire bus_stop  = scl_s && scl_q && !sda_q && sda_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= M_IDLE;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
      sh       <= '0;
      cnt      <= '0;
      sda_pull <= 1'b0;
      hit      <= 1'b0;
      rd       <= 1'b0;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
      if (!en) begin
        st       <= M_IDLE;
        sda_pull <= 1'b0;
        hit      <= 1'b0;
        rd       <= 1'b0;
      end else if (bus_start) begin
        st       <= M_ADDR;
        cnt      <= '0;
        sda_pull <= 1'b0;
        hit      <= 1'b0;
        rd       <= 1'b0;
      end else if (bus_stop) begin
        st       <= M_IDLE;
        sda_pull <= 1'b0;
        hit      <= 1'b0;
        rd       <= 1'b0;
      end else begin
        case (st)
          M_ADDR: begin
            if (scl_rise && cnt < 4'd8) begin
              sh  <= {sh[6:0], sda_s};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              if (sh[7:1] == my_addr) begin
                sda_pull <= 1'b1;
                st       <= M_ACK;
              end else begin
                st <= M_SKIP;
              end
            end
          end
          M_ACK: begin
            if (scl_fall) begin
              sda_pull <= 1'b0;
              hit      <= 1'b1;
              rd       <= sh[0];
              st       <= M_HELD;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/bus_role_picker.sv
module bus_role_picker
  import bus_role_pkg::*;
#(
  parameter int         CLK_HZ    = 125_000_000,
  parameter int         SCL_HZ    = 100_000,
  parameter logic [6:0] MEM_ADDR  = 7'h50,
  parameter logic [7:0] MEM_LOC   = 8'h00,
  parameter logic [7:0] TEST_BYTE = 8'hA5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_addr_en,
  input  logic [6:0] cfg_addr,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_pull,
  output logic       sda_pull,
  output logic       role_master,
  output logic       probe_done,
  output logic       addr_hit,
  output logic       addr_rd
);
  logic       scl_s, sda_s;
  logic       m_scl, m_sda, m_done, m_pass;
  logic       s_sda;
  logic       settled;
  logic [6:0] my_addr;

  line_sync #(.W(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({scl_i, sda_i}),
    .q     ({scl_s, sda_s})
  );

  probe_master #(
    .CLK_HZ    (CLK_HZ),
    .SCL_HZ    (SCL_HZ),
    .MEM_ADDR  (MEM_ADDR),
    .MEM_LOC   (MEM_LOC),
    .TEST_BYTE (TEST_BYTE)
  ) u_probe (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_s      (scl_s),
    .sda_s      (sda_s),
    .scl_pull   (m_scl),
    .sda_pull   (m_sda),
    .done_pulse (m_done),
    .pass       (m_pass)
  );

  // Own address captured once, when the role is settled
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      settled <= 1'b0;
      my_addr <= FACTORY_ADDR;
    end else if (m_done) begin
      settled <= 1'b1;
      my_addr <= cfg_addr_en ? cfg_addr : FACTORY_ADDR;
    end
  end

  addr_matcher u_match (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (settled && !m_pass),
    .my_addr  (my_addr),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .sda_pull (s_sda),
    .hit      (addr_hit),
    .rd       (addr_rd)
  );

  assign scl_pull    = m_scl;
  assign sda_pull    = m_sda | s_sda;
  assign role_master = m_pass;
  assign probe_done  = m_done;
endmodule

// File: rtl/role_checker.sv
module role_checker (
  input logic clk,
  input logic rst_n,
  input logic role_master,
  input logic probe_done,
  input logic addr_hit,
  input logic scl_pull,
  input logic sda_pull
);
  logic seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          seen <= 1'b0;
    else if (probe_done) seen <= 1'b1;
  end

  p_single_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> !probe_done);

  p_bus_idle_at_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    probe_done |-> (!scl_pull && !sda_pull));

  p_role_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> $stable(role_master));

  p_no_early_role_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!seen && !probe_done) |-> !role_master);

  p_hit_slave_only_r11: assert property (@(posedge clk) disable iff (!rst_n)
    addr_hit |-> (seen && !role_master));

  p_no_clock_drive_r11: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> !scl_pull);
endmodule

bind bus_role_picker role_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .role_master (role_master),
  .probe_done  (probe_done),
  .addr_hit    (addr_hit),
  .scl_pull    (scl_pull),
  .sda_pull    (sda_pull)
);

// File: tb/sim_bus_role_picker.sv
module sim_bus_role_picker;
  localparam int         CLK_HZ = 125_000_000;
  localparam int         SCL_HZ = 10_000_000;
  localparam logic [7:0] LOC    = 8'h3C;
  localparam logic [7:0] TBYTE  = 8'hA5;
  localparam int         H      = 20;
  localparam int         MINPER = (CLK_HZ + SCL_HZ - 1) / SCL_HZ;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       cfg_addr_en = 1'b0;
  logic [6:0] cfg_addr = 7'h00;
  logic       host_scl = 1'b0, host_sda = 1'b0, mem_pull = 1'b0;
  logic       dut_scl, dut_sda, role_master, probe_done, addr_hit, addr_rd;

  wire scl_line = ~(dut_scl | host_scl);
  wire sda_line = ~(dut_sda | host_sda | mem_pull);

  bus_role_picker #(
    .CLK_HZ (CLK_HZ), .SCL_HZ (SCL_HZ), .MEM_LOC (LOC), .TEST_BYTE (TBYTE)
  ) u0 (
    .clk (clk), .rst_n (rst_n), .cfg_addr_en (cfg_addr_en), .cfg_addr (cfg_addr),
    .scl_i (scl_line), .sda_i (sda_line), .scl_pull (dut_scl), .sda_pull (dut_sda),
    .role_master (role_master), .probe_done (probe_done),
    .addr_hit (addr_hit), .addr_rd (addr_rd)
  );

  int total = 0, bad = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- memory model (0 present, 1 absent, 2 corrupt) ----------
  int         mode = 0;
  logic       m_scl_q, m_sda_q, m_sel, m_read;
  logic [3:0] m_bitc;
  int         m_byten;
  logic [7:0] m_sh, m_ptr, m_store;
  logic [7:0] log_b [0:15];
  int         log_n, starts, stops;
  logic [7:0] rdval;

  always @(negedge clk) begin
    if (!rst_n) begin
      m_scl_q = 1'b1; m_sda_q = 1'b1; m_sel = 1'b0; m_read = 1'b0;
      m_bitc = 4'd0; m_byten = 0; m_sh = 8'h00; m_ptr = 8'h00; m_store = 8'h00;
      log_n = 0; starts = 0; stops = 0; mem_pull = 1'b0;
    end else begin
      rdval = (mode == 2) ? (m_store ^ 8'h01) : m_store;
      if (scl_line && m_scl_q && m_sda_q && !sda_line) begin
        starts++; m_bitc = 4'd0; m_byten = 0; m_sel = 1'b0; m_read = 1'b0; mem_pull = 1'b0;
      end else if (scl_line && m_scl_q && !m_sda_q && sda_line) begin
        stops++; m_bitc = 4'd0; m_byten = 0; m_sel = 1'b0; mem_pull = 1'b0;
      end else if (scl_line && !m_scl_q) begin
        if (m_bitc < 4'd8) m_sh = {m_sh[6:0], sda_line};
        m_bitc = m_bitc + 4'd1;
      end else if (!scl_line && m_scl_q) begin
        if (m_bitc == 4'd8) begin
          if (m_byten == 0) begin
            if (log_n < 16) log_b[log_n] = m_sh;
            log_n++;
            m_sel = (m_sh[7:1] == 7'h50) && (mode != 1);
            m_read = m_sh[0];
            mem_pull = m_sel;
          end else if (!m_read) begin
            if (log_n < 16) log_b[log_n] = m_sh;
            log_n++;
            mem_pull = m_sel;
            if (m_sel && m_byten == 1) m_ptr = m_sh;
            if (m_sel && m_byten == 2) m_store = m_sh;
          end else begin
            mem_pull = 1'b0;
          end
        end else if (m_bitc == 4'd9) begin
          mem_pull = 1'b0; m_bitc = 4'd0; m_byten++;
          if (m_sel && m_read) mem_pull = ~rdval[7];
        end else if (m_sel && m_read && m_byten >= 1 && m_bitc >= 4'd1 && m_bitc <= 4'd7) begin
          mem_pull = ~rdval[3'd7 - m_bitc[2:0]];
        end
      end
      m_scl_q = scl_line; m_sda_q = sda_line;
    end
  end

  // ---------------- monitor ----------------
  int   pulses, minper, pcnt;
  logic last_scl, had_rise, done_seen, idle_at_done;

  always @(negedge clk) begin
    if (!rst_n) begin
      pulses = 0; minper = 1000000; pcnt = 0; last_scl = 1'b1;
      had_rise = 1'b0; done_seen = 1'b0; idle_at_done = 1'b0;
    end else begin
      pcnt++;
      if (scl_line && !last_scl) begin
        if (!done_seen && had_rise && pcnt < minper) minper = pcnt;
        pcnt = 0; had_rise = 1'b1;
      end
      last_scl = scl_line;
      if (probe_done) begin
        pulses++; done_seen = 1'b1; idle_at_done = scl_line && sda_line;
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input int md);
    @(negedge clk);
    rst_n = 1'b0; host_scl = 1'b0; host_sda = 1'b0; mode = md;
    wait_n(5);
    rst_n = 1'b1;
  endtask

  task automatic wait_done(input string tag);
    int n = 0;
    while (!done_seen && n < 20000) begin
      @(negedge clk); n++;
    end
    chk(done_seen, tag, int'(done_seen), 1);
  endtask

  task automatic host_xfer(input logic [7:0] b, output bit ack, output bit hit,
                           output bit rd, output bit hit_after);
    host_sda = 1'b0; host_scl = 1'b0; wait_n(H);
    host_sda = 1'b1; wait_n(H);
    host_scl = 1'b1; wait_n(H);
    for (int i = 7; i >= 0; i--) begin
      host_sda = ~b[i]; wait_n(H);
      host_scl = 1'b0; wait_n(H);
      host_scl = 1'b1;
    end
    host_sda = 1'b0; wait_n(H);
    host_scl = 1'b0; wait_n(H / 2);
    ack = ~sda_line; wait_n(H / 2);
    host_scl = 1'b1; wait_n(H);
    hit = addr_hit; rd = addr_rd;
    host_sda = 1'b1; wait_n(H);
    host_scl = 1'b0; wait_n(H);
    host_sda = 1'b0; wait_n(H);
    hit_after = addr_hit;
  endtask

  // ---------------- scenarios ----------------
  task automatic test_reset();
    @(negedge clk); rst_n = 1'b0; wait_n(4);
    chk(!dut_scl && !dut_sda, "R1 lines released in reset", {dut_scl, dut_sda}, 0);
    chk(!role_master && !probe_done && !addr_hit, "R1 outputs low in reset",
        {role_master, probe_done, addr_hit}, 0);
  endtask

  task automatic test_present();
    bit ack, hit, rd, ha;
    cfg_addr_en = 1'b0;
    do_reset(0);
    wait_done("R4 probe finished (present)");
    wait_n(2);
    chk(role_master, "R5 master role when memory answers", int'(role_master), 1);
    chk(pulses == 1, "R4 single strobe", pulses, 1);
    chk(idle_at_done, "R4 bus idle at strobe", int'(idle_at_done), 1);
    chk(log_n == 6 && log_b[0] == 8'hA0 && log_b[1] == LOC && log_b[2] == TBYTE &&
        log_b[3] == 8'hA0 && log_b[4] == LOC && log_b[5] == 8'hA1,
        "R2 probe byte order", log_n, 6);
    chk(starts == 3 && stops == 2, "R2 start/stop count", starts * 16 + stops, 3 * 16 + 2);
    chk(minper >= MINPER, "R3 clock period", minper, MINPER);
    host_xfer(8'h84, ack, hit, rd, ha);
    chk(!ack && !hit, "R11 master role ignores own address", {ack, hit}, 0);
    wait_n(3000);
    chk(pulses == 1 && role_master, "R5 role held, no second probe",
        pulses * 2 + int'(role_master), 3);
  endtask

  task automatic test_absent();
    bit ack, hit, rd, ha;
    cfg_addr_en = 1'b0;
    do_reset(1);
    wait_done("R6 probe finished (absent)");
    wait_n(2);
    chk(!role_master, "R6 slave role on NACK", int'(role_master), 0);
    chk(log_n == 1 && log_b[0] == 8'hA0 && starts == 1 && stops == 1,
        "R6 aborted after address byte", log_n, 1);
    host_xfer(8'h84, ack, hit, rd, ha);
    chk(ack, "R9 ACK on default address write (R8 default 0x42)", int'(ack), 1);
    chk(hit && !rd, "R9 hit with write direction", {hit, rd}, 2);
    chk(!ha, "R9 hit cleared by STOP", int'(ha), 0);
    host_xfer(8'h85, ack, hit, rd, ha);
    chk(ack && hit && rd, "R9 hit with read direction", {ack, hit, rd}, 7);
    host_xfer(8'h90, ack, hit, rd, ha);
    chk(!ack && !hit, "R10 foreign address ignored", {ack, hit}, 0);
  endtask

  task automatic test_corrupt();
    do_reset(2);
    wait_done("R7 probe finished (corrupt)");
    wait_n(2);
    chk(!role_master, "R7 slave role on read-back mismatch", int'(role_master), 0);
    chk(log_n == 6 && stops == 2, "R7 full probe ran", log_n, 6);
  endtask

  task automatic test_cfg_addr();
    bit ack, hit, rd, ha;
    cfg_addr_en = 1'b1; cfg_addr = 7'h33;
    do_reset(1);
    wait_done("R8 probe finished (configured address)");
    wait_n(2);
    cfg_addr = 7'h55;
    host_xfer(8'h66, ack, hit, rd, ha);
    chk(ack && hit, "R8 configured address answered", {ack, hit}, 3);
    host_xfer(8'h84, ack, hit, rd, ha);
    chk(!ack && !hit, "R8 default not used when configured", {ack, hit}, 0);
    host_xfer(8'hAA, ack, hit, rd, ha);
    chk(!ack && !hit, "R8 late cfg change ignored", {ack, hit}, 0);
    cfg_addr_en = 1'b0;
  endtask

  initial begin
    test_reset();
    test_present();
    test_absent();
    test_corrupt();
    test_cfg_addr();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule